// File: doc/BRIEF.md
# Memory pair duplication sequencer

This block makes one pass over a display memory and leaves each even/odd address pair holding the same word. It walks a counter from 0 to the top address. For each counter value it runs a read phase and then a write phase. In the read phase the word at the counter address is taken into a holding latch. In the write phase that latch is written back with the lowest address bit cleared. As a result, each even word is rewritten with its own value, each odd word is copied into its even neighbour, and every pair ends up holding the value of its odd member.

The block drives the memory's address, write data and write strobe, and it reads the memory's data combinationally. A one-cycle start request in the idle state begins a pass. A busy flag covers the whole pass. A single-cycle done pulse follows the final write, and the block then returns to idle. The default configuration is 1024 words of 8 bits, with read and write phases of two clock cycles each.

Top module: `pair_dup_seq`

## Requirements
- R1: After reset, busy, done and mem_we are 0, and mem_addr is 0.
- R2: A start pulse sampled while idle makes busy 1 from the next cycle. The first cycle of the pass is a read phase at address 0.
- R3: For each counter value c, from 0 upward, there are PHASE_CYC read cycles and then PHASE_CYC write cycles. The counter changes only when the next read phase begins. In cycle k of the pass, mem_addr is k/(2·PHASE_CYC) during read cycles (k mod 2·PHASE_CYC < PHASE_CYC). During write cycles it is that value with bit 0 cleared.
- R4: The latch samples mem_rdata only in the first cycle of each read phase. The data returned in later read cycles has no effect on what is written.
- R5: mem_we is 1 only in the last cycle of each write phase. At that point mem_wdata equals the word read for the current counter value.
- R6: When the pass ends, for every even address 2j, both words 2j and 2j+1 hold the original value of word 2j+1.
- R7: done is 1 for exactly one cycle, in the cycle after the final write (counter at the top value, address top−1). busy falls in that same cycle. busy is therefore high for exactly DEPTH·2·PHASE_CYC cycles.
- R8: A start pulse received while busy is ignored. The pass continues with no change to its address sequence or length.
- R9: mem_we is never 1 while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a pass; acted on only while idle |
| mem_rdata | input | DATA_W | Read data from the memory (combinational read) |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data, taken from the holding latch |
| mem_we | output | 1 | Write strobe |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse when a pass completes |

## Verification
The checker tests on every cycle that writes happen only while busy and only to even addresses, and that the write data holds steady while it is being written. It also checks that done is a single-cycle pulse ending busy, and that a start request from idle always raises busy. What the assertions cannot see is the full address order, whether the latch sampled in the right cycle, and the final memory contents. The bench covers these with a full pass over a modelled memory, checked against arithmetic predictions. In one of its passes it corrupts the read data in the late read cycles and injects a start request partway through.

// File: rtl/pds_pkg.sv
package pds_pkg;
   typedef enum logic [1:0] {
      PDS_IDLE  = 2'd0,
      PDS_READ  = 2'd1,
      PDS_WRITE = 2'd2
   } pds_phase_e;
endpackage

// File: rtl/pds_phase_ctrl.sv
module pds_phase_ctrl
   import pds_pkg::*;
#(
   parameter int PHASE_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic last_count,
   output logic busy,
   output logic latch_stb,
   output logic write_stb,
   output logic is_write,
   output logic step,
   output logic finish
);
   localparam int SUB_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(PHASE_CYC - 1);

   pds_phase_e phase_q, phase_d;
   logic [SUB_W-1:0] sub_q, sub_d;
   logic sub_end;

   assign sub_end = (sub_q == SUB_LAST);

   always_comb begin
      phase_d = phase_q;
      sub_d   = sub_q;
      case (phase_q)
         PDS_IDLE: begin
            sub_d = '0;
            if (start) phase_d = PDS_READ;
         end
         PDS_READ: begin
            if (sub_end) begin
               phase_d = PDS_WRITE;
               sub_d   = '0;
            end else begin
               sub_d = sub_q + 1'b1;
            end
         end
         PDS_WRITE: begin
            if (sub_end) begin
               phase_d = last_count ? PDS_IDLE : PDS_READ;
               sub_d   = '0;
            end else begin
               sub_d = sub_q + 1'b1;
            end
         end
         default: begin
            phase_d = PDS_IDLE;
            sub_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PDS_IDLE;
         sub_q   <= '0;
      end else begin
         phase_q <= phase_d;
         sub_q   <= sub_d;
      end
   end

   assign busy      = (phase_q != PDS_IDLE);
   assign is_write  = (phase_q == PDS_WRITE);
   assign latch_stb = (phase_q == PDS_READ) && (sub_q == '0);
   assign write_stb = is_write && sub_end;
   assign step      = write_stb && !last_count;
   assign finish    = write_stb && last_count;
endmodule

// File: rtl/pds_addr_ctr.sv
module pds_addr_ctr #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   output logic [ADDR_W-1:0] count,
   output logic              at_top
);
   localparam logic [ADDR_W-1:0] TOP = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)       count <= '0;
      else if (advance) count <= count + 1'b1;
   end

   assign at_top = (count == TOP);
endmodule

// File: rtl/pds_hold_latch.sv
module pds_hold_latch #(
   parameter int DATA_W    = 8,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   generate
      if (RESET_VAL) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n)       q <= '0;
            else if (capture) q <= d;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (capture) q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/pair_dup_seq.sv
module pair_dup_seq #(
   parameter int ADDR_W    = 10,
   parameter int DATA_W    = 8,
   parameter int PHASE_CYC = 2,
   parameter bit LATCH_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              busy,
   output logic              done
);
   generate
      if (ADDR_W < 2)    begin : g_bad_aw $error("ADDR_W must be at least 2"); end
      if (DATA_W < 1)    begin : g_bad_dw $error("DATA_W must be at least 1"); end
      if (PHASE_CYC < 2) begin : g_bad_pc $error("PHASE_CYC must be at least 2"); end
   endgenerate

   logic [ADDR_W-1:0] count;
   logic at_top, latch_stb, write_stb, is_write, step, finish;
   logic done_q;

   pds_phase_ctrl #(.PHASE_CYC(PHASE_CYC)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .last_count(at_top),
      .busy(busy), .latch_stb(latch_stb), .write_stb(write_stb),
      .is_write(is_write), .step(step), .finish(finish)
   );

   pds_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .advance(step | finish),
      .count(count), .at_top(at_top)
   );

   pds_hold_latch #(.DATA_W(DATA_W), .RESET_VAL(LATCH_RST)) u_latch (
      .clk(clk), .rst_n(rst_n), .capture(latch_stb),
      .d(mem_rdata), .q(mem_wdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= finish;
   end

   assign mem_addr = is_write ? {count[ADDR_W-1:1], 1'b0} : count;
   assign mem_we   = write_stb;
   assign done     = done_q;
endmodule

// File: rtl/pds_checker.sv
module pds_checker #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_we,
   input logic              busy,
   input logic              done
);
   AST_NO_WE_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_we); // R9
   AST_WE_EVEN:        assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> (mem_addr[0] == 1'b0)); // R5
   AST_WDATA_HELD:     assert property (@(posedge clk) disable iff (!rst_n) busy && $past(busy) && mem_we |-> $stable(mem_wdata)); // R4
   AST_DONE_SINGLE:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> !busy && $past(busy)); // R7
   AST_START_BUSY:     assert property (@(posedge clk) disable iff (!rst_n) !busy && start |=> busy); // R2
   AST_BUSY_HOLDS:     assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R8
endmodule

bind pair_dup_seq pds_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pds_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .mem_we(mem_we), .busy(busy), .done(done)
);

// File: tb/pair_dup_seq_bench.sv
module pair_dup_seq_bench;
   localparam int AW = 10;
   localparam int DW = 8;
   localparam int PC = 2;
   localparam int DEPTH = 1 << AW;
   localparam int PER = 2 * PC;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic glitch = 1'b0;
   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] orig [DEPTH];
   logic [DW-1:0] mem_rdata;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic mem_we, busy, done;
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   assign mem_rdata = mem[mem_addr] ^ (glitch ? 8'hFF : 8'h00);

   always_ff @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

   pair_dup_seq #(.ADDR_W(AW), .DATA_W(DW), .PHASE_CYC(PC)) u_pair_dup_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic fill(input int seed);
      for (int i = 0; i < DEPTH; i++) begin
         orig[i] = DW'((i * seed + 11 + (i >> 3)) & 8'hFF);
         mem[i]  = orig[i];
      end
   endtask

   task automatic run_pass(input bit corrupt, input bit restart);
      int addr_bad, we_bad, data_bad, busy_bad, first_bad_k;
      addr_bad = 0; we_bad = 0; data_bad = 0; busy_bad = 0; first_bad_k = -1;
      @(negedge clk) start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      for (int k = 0; k < DEPTH * PER; k++) begin
         int c, ph, ea;
         c  = k / PER;
         ph = k % PER;
         glitch = corrupt && (ph > 0) && (ph < PC);
         start  = restart && (k == 777);
         ea = (ph < PC) ? c : (c & ~1);
         #4;
         if (k == 0) begin
            chk(busy == 1'b1, "R2 busy after start", busy, 1);
            chk(mem_addr == 0, "R2 first address", mem_addr, 0);
         end
         if (mem_addr != AW'(ea)) begin addr_bad++; if (first_bad_k < 0) first_bad_k = k; end
         if (mem_we != (ph == PER - 1)) we_bad++;
         if (mem_we && mem_wdata != orig[c]) data_bad++;
         if (!busy || done) busy_bad++;
         @(posedge clk); #1;
      end
      glitch = 1'b0;
      start  = 1'b0;
      #4;
      chk(addr_bad == 0, "R3 address sequence mismatches", addr_bad, 0);
      chk(we_bad == 0, "R5 write strobe timing mismatches", we_bad, 0);
      chk(data_bad == 0, corrupt ? "R4 write data with late corruption" : "R5 write data",
          data_bad, 0);
      chk(busy_bad == 0, restart ? "R8 pass disturbed by start" : "R7 busy length", busy_bad, 0);
      chk(done == 1'b1, "R7 done after last write", done, 1);
      chk(busy == 1'b0, "R7 busy falls with done", busy, 0);
      @(posedge clk); #5;
      chk(done == 1'b0, "R7 done one cycle only", done, 0);
      begin
         int bad;
         bad = 0;
         for (int i = 0; i < DEPTH; i++) if (mem[i] !== orig[i | 1]) bad++;
         chk(bad == 0, "R6 pair contents", bad, 0);
      end
      begin
         int we_idle;
         we_idle = 0;
         for (int i = 0; i < 20; i++) begin
            @(posedge clk); #5;
            if (mem_we || busy) we_idle++;
         end
         chk(we_idle == 0, "R9 no write while idle", we_idle, 0);
      end
   endtask

   initial begin
      fill(37);
      repeat (3) @(posedge clk);
      #5;
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(done == 1'b0, "R1 done", done, 0);
      chk(mem_we == 1'b0, "R1 we", mem_we, 0);
      chk(mem_addr == 0, "R1 addr", mem_addr, 0);
      @(negedge clk) rst_n = 1'b1;
      repeat (4) @(posedge clk);
      run_pass(1'b0, 1'b0);
      fill(101);
      run_pass(1'b1, 1'b1);
      fill(5);
      run_pass(1'b1, 1'b0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule